// File: doc/BRIEF.md
# Readback and Update Request Arbiter

This block sits at the front of one counter channel. Two requesters share a single request output. The first is a stream of statistics updates from the packet side, each carrying a counter address and an increment. The second is an occasional readback from the host processor, carrying only a counter address. A readback always takes precedence. Once the arbiter accepts a readback, it holds that readback in a one-entry slot and presents it on the output on the next clock. Until the readback leaves, the arbiter withholds the statistics ready signal, which pushes backpressure toward the packet source.

After each readback is handed downstream, the readback input is refused for a programmable number of clocks. This keeps readbacks spread out in time, so they cannot starve the update stream. Every output request carries a one-bit kind tag. The logic that performs the counter read-modify-write uses this tag to tell a readback from an update.

All handshakes are valid/ready. A transfer occurs on a rising edge where both valid and ready are high. Nothing is buffered except the single pending readback, and no request is dropped.

Top module: `stats_rdbk_arb`

## Requirements
- R1: After reset, no readback is pending, the lockout is idle, `rb_ready` is 1, and `out_valid` equals `st_valid`.
- R2: A readback accepted on a clock edge appears on the output in the next cycle with `out_kind` = 1 and `out_addr` equal to the accepted address.
- R3: While a readback is pending, `st_ready` is 0, and the output carries the readback rather than the statistics request.
- R4: With no readback pending, the output mirrors the statistics input: `out_valid` = `st_valid`, `out_kind` = 0, `out_addr`/`out_data` equal to `st_addr`/`st_data`, and `st_ready` = `out_ready`.
- R5: A pending readback stays on the output with an unchanged address until `out_ready` is 1.
- R6: After a readback is transferred at the output, `rb_ready` is 0 for exactly `LOCK_CYC` cycles and then returns to 1.
- R7: While readbacks are locked out, a valid statistics request is served even if a readback is also valid.
- R8: Every accepted readback and every accepted statistics request leaves the output exactly once.
- R9: A readback request on the output carries `out_data` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Statistics update present |
| st_ready | output | 1 | Statistics update taken this cycle |
| st_addr | input | ADDR_W | Counter address of the update |
| st_data | input | DATA_W | Increment carried by the update |
| rb_valid | input | 1 | Processor readback present |
| rb_ready | output | 1 | Readback taken this cycle |
| rb_addr | input | ADDR_W | Counter address to read back |
| out_valid | output | 1 | Request presented downstream |
| out_ready | input | 1 | Downstream takes the request |
| out_kind | output | 1 | 1 for a readback, 0 for an update |
| out_addr | output | ADDR_W | Request address |
| out_data | output | DATA_W | Update increment, zero for a readback |

## Verification
The properties assume that both requesters follow the usual valid/ready discipline: a source that raises valid keeps its address and data unchanged until a transfer takes place. The bench's sources keep to this rule by changing a payload only after a transfer it has seen, or while valid is low.

The downstream ready is treated as arbitrary. The bench toggles it with several densities, including stretches where it stays low, so that a readback is held across many cycles. Readback valid is sometimes held high continuously, which makes the lockout boundary fall on an exact cycle that can be checked.

// File: rtl/stats_arb_pkg.sv
package stats_arb_pkg;

    typedef enum logic {
        REQ_UPDATE   = 1'b0,
        REQ_READBACK = 1'b1
    } req_kind_e;

    // Width of a down-counter able to hold the value n (n >= 1).
    function automatic int unsigned cnt_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/rdbk_slot.sv
module rdbk_slot #(
    parameter int unsigned ADDR_W = 22
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic [ADDR_W-1:0] take_addr,
    input  logic              release_i,
    output logic              pend,
    output logic [ADDR_W-1:0] pend_addr
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend      <= 1'b0;
            pend_addr <= '0;
        end else if (take) begin
            pend      <= 1'b1;
            pend_addr <= take_addr;
        end else if (release_i) begin
            pend      <= 1'b0;
        end
    end

endmodule

// File: rtl/lockout_timer.sv
module lockout_timer
    import stats_arb_pkg::*;
#(
    parameter int unsigned LOCK_CYC = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    output logic idle
);

    localparam int unsigned CW = cnt_width(LOCK_CYC);
    localparam logic [CW-1:0] RELOAD = CW'(LOCK_CYC);

    logic [CW-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= '0;
        end else if (arm) begin
            remain <= RELOAD;
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign idle = (remain == '0);

endmodule

// File: rtl/req_mux.sv
module req_mux
    import stats_arb_pkg::*;
#(
    parameter int unsigned ADDR_W = 22,
    parameter int unsigned DATA_W = 72
) (
    input  logic              pend,
    input  logic [ADDR_W-1:0] pend_addr,
    input  logic              st_valid,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [DATA_W-1:0] st_data,
    input  logic              out_ready,
    output logic              st_ready,
    output logic              out_valid,
    output req_kind_e         out_kind,
    output logic [ADDR_W-1:0] out_addr,
    output logic [DATA_W-1:0] out_data
);

    always_comb begin
        if (pend) begin
            out_valid = 1'b1;
            out_kind  = REQ_READBACK;
            out_addr  = pend_addr;
            out_data  = '0;
            st_ready  = 1'b0;
        end else begin
            out_valid = st_valid;
            out_kind  = REQ_UPDATE;
            out_addr  = st_addr;
            out_data  = st_data;
            st_ready  = out_ready;
        end
    end

endmodule

// File: rtl/stats_rdbk_arb.sv
module stats_rdbk_arb
    import stats_arb_pkg::*;
#(
    parameter int unsigned ADDR_W   = 22,
    parameter int unsigned DATA_W   = 72,
    parameter int unsigned LOCK_CYC = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              st_valid,
    output logic              st_ready,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [DATA_W-1:0] st_data,
    input  logic              rb_valid,
    output logic              rb_ready,
    input  logic [ADDR_W-1:0] rb_addr,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              out_kind,
    output logic [ADDR_W-1:0] out_addr,
    output logic [DATA_W-1:0] out_data
);

    logic              pend;
    logic [ADDR_W-1:0] pend_addr;
    logic              lock_idle;
    logic              rb_take;
    logic              rb_done;
    req_kind_e         kind;

    assign rb_ready = !pend && lock_idle;
    assign rb_take  = rb_valid && rb_ready;
    assign rb_done  = pend && out_ready;

    rdbk_slot #(.ADDR_W(ADDR_W)) u_slot (
        .clk       (clk),
        .rst       (rst),
        .take      (rb_take),
        .take_addr (rb_addr),
        .release_i (rb_done),
        .pend      (pend),
        .pend_addr (pend_addr)
    );

    lockout_timer #(.LOCK_CYC(LOCK_CYC)) u_lock (
        .clk  (clk),
        .rst  (rst),
        .arm  (rb_done),
        .idle (lock_idle)
    );

    req_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mux (
        .pend      (pend),
        .pend_addr (pend_addr),
        .st_valid  (st_valid),
        .st_addr   (st_addr),
        .st_data   (st_data),
        .out_ready (out_ready),
        .st_ready  (st_ready),
        .out_valid (out_valid),
        .out_kind  (kind),
        .out_addr  (out_addr),
        .out_data  (out_data)
    );

    assign out_kind = kind;

endmodule

// File: rtl/stats_rdbk_arb_chk.sv
module stats_rdbk_arb_chk
    import stats_arb_pkg::*;
#(
    parameter int unsigned ADDR_W   = 22,
    parameter int unsigned DATA_W   = 72,
    parameter int unsigned LOCK_CYC = 10
) (
    input logic              clk,
    input logic              rst,
    input logic              st_valid,
    input logic              st_ready,
    input logic [ADDR_W-1:0] st_addr,
    input logic [DATA_W-1:0] st_data,
    input logic              rb_valid,
    input logic              rb_ready,
    input logic [ADDR_W-1:0] rb_addr,
    input logic              out_valid,
    input logic              out_ready,
    input logic              out_kind,
    input logic [ADDR_W-1:0] out_addr,
    input logic [DATA_W-1:0] out_data
);

    localparam int unsigned CW = cnt_width(LOCK_CYC);

    logic          rb_out;
    logic          rb_fire;
    logic [CW-1:0] win;

    assign rb_out  = out_valid && (out_kind == REQ_READBACK);
    assign rb_fire = rb_out && out_ready;

    // Independent lockout window, counted from the output transfer.
    always_ff @(posedge clk) begin
        if (rst)              win <= '0;
        else if (rb_fire)     win <= CW'(LOCK_CYC);
        else if (win != '0)   win <= win - 1'b1;
    end

    p_rdbk_next_r2: assert property (@(posedge clk) disable iff (rst)
        (rb_valid && rb_ready) |=> (rb_out && out_addr == $past(rb_addr)));

    p_hold_off_r3: assert property (@(posedge clk) disable iff (rst)
        rb_out |-> !st_ready);

    p_pass_r4: assert property (@(posedge clk) disable iff (rst)
        (st_valid && st_ready) |-> (out_valid && out_ready && !out_kind
                                    && out_addr == st_addr && out_data == st_data));

    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (rb_out && !out_ready) |=> (rb_out && $stable(out_addr)));

    p_lock_r6: assert property (@(posedge clk) disable iff (rst)
        (win != '0) |-> !rb_ready);

    p_reopen_r6: assert property (@(posedge clk) disable iff (rst)
        (win == '0 && !rb_out) |-> rb_ready);

    p_zero_r9: assert property (@(posedge clk) disable iff (rst)
        rb_out |-> (out_data == '0));

endmodule

bind stats_rdbk_arb stats_rdbk_arb_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LOCK_CYC(LOCK_CYC)
) u_chk (
    .clk(clk), .rst(rst),
    .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr), .st_data(st_data),
    .rb_valid(rb_valid), .rb_ready(rb_ready), .rb_addr(rb_addr),
    .out_valid(out_valid), .out_ready(out_ready), .out_kind(out_kind),
    .out_addr(out_addr), .out_data(out_data)
);

// File: tb/sim_stats_rdbk_arb.sv
`timescale 1ns/1ps
module sim_stats_rdbk_arb;

    localparam int AW   = 22;
    localparam int DW   = 72;
    localparam int LOCK = 10;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          st_valid = 1'b0, rb_valid = 1'b0, out_ready = 1'b0;
    logic [AW-1:0] st_addr = '0, rb_addr = '0;
    logic [DW-1:0] st_data = '0;
    logic          st_ready, rb_ready, out_valid, out_kind;
    logic [AW-1:0] out_addr;
    logic [DW-1:0] out_data;

    int checks = 0, fails = 0;
    bit done = 1'b0;

    // reference model state
    bit            m_pend = 1'b0;
    logic [AW-1:0] m_addr = '0;
    int            m_cnt = 0;
    int            rb_in = 0, rb_outn = 0, st_in = 0, st_outn = 0;
    int            rb_dens = 10, st_dens = 50, rdy_dens = 70;
    bit            rb_hold = 1'b0;

    always #5 clk = ~clk;

    stats_rdbk_arb u0 (
        .clk(clk), .rst(rst),
        .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr), .st_data(st_data),
        .rb_valid(rb_valid), .rb_ready(rb_ready), .rb_addr(rb_addr),
        .out_valid(out_valid), .out_ready(out_ready), .out_kind(out_kind),
        .out_addr(out_addr), .out_data(out_data)
    );

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // One clock: compare at negedge, advance model at posedge, drive after it.
    task automatic step();
        bit st_fire, rb_fire, o_fire;
        @(negedge clk);
        chk("R1 R3 R4 out_valid", DW'(out_valid), DW'(m_pend | st_valid));
        chk("R2 R3 out_kind", DW'(out_kind), DW'(m_pend));
        chk("R2 R4 R5 out_addr", DW'(out_addr), DW'(m_pend ? m_addr : st_addr));
        chk("R4 R9 out_data", out_data, m_pend ? '0 : st_data);
        chk("R3 R4 st_ready", DW'(st_ready), DW'(out_ready & !m_pend));
        chk("R1 R6 rb_ready", DW'(rb_ready), DW'(!m_pend && m_cnt == 0));
        if (m_cnt > 0 && st_valid && out_ready)
            chk("R7 update served in lockout", DW'(st_ready), 1);
        st_fire = st_valid && !m_pend && out_ready;
        rb_fire = rb_valid && !m_pend && m_cnt == 0;
        o_fire  = out_valid && out_ready;
        if (o_fire && out_kind)  rb_outn++;
        if (o_fire && !out_kind) st_outn++;
        if (st_fire) st_in++;
        if (rb_fire) rb_in++;
        @(posedge clk);
        if (m_pend && out_ready) begin m_pend = 1'b0; m_cnt = LOCK; end
        else if (m_cnt > 0) m_cnt--;
        if (rb_fire) begin m_pend = 1'b1; m_addr = rb_addr; end
        #1;
        if (!st_valid || st_fire) begin
            st_valid = ($urandom_range(99) < st_dens);
            st_addr  = AW'($urandom);
            st_data  = {$urandom, $urandom, $urandom};
        end
        if (!rb_valid || rb_fire) begin
            rb_valid = rb_hold || ($urandom_range(99) < rb_dens);
            rb_addr  = AW'($urandom);
        end
        out_ready = ($urandom_range(99) < rdy_dens);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R1: reset state with idle inputs
        @(negedge clk);
        chk("R1 rb_ready after reset", DW'(rb_ready), 1);
        chk("R1 out_valid after reset", DW'(out_valid), 0);

        // R2 R6: one readback, downstream always ready, readback valid held high
        @(posedge clk); #1;
        out_ready = 1'b1; rb_valid = 1'b1; rb_addr = 22'h2AAAA; rb_hold = 1'b1;
        rb_dens = 100; rdy_dens = 100; st_dens = 100;
        repeat (40) step();

        // R5: readbacks held against a mostly stalled downstream
        rb_hold = 1'b0; rb_dens = 60; rdy_dens = 15; st_dens = 80;
        repeat (400) step();

        // mixed traffic, several densities
        for (int ph = 0; ph < 6; ph++) begin
            rb_dens  = 5 + ph * 15;
            st_dens  = 30 + ph * 10;
            rdy_dens = 40 + ph * 10;
            repeat (1500) step();
        end

        // drain, then R8 accounting
        st_dens = 0; rb_dens = 0; rdy_dens = 100;
        repeat (30) step();
        chk("R8 readbacks in vs out", DW'(rb_outn), DW'(rb_in));
        chk("R8 updates in vs out", DW'(st_outn), DW'(st_in));
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule